// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block gives an external debugger a way to read and write target memory without going through a processor. The debugger programs a small register file over a simple word-wide register port. The files are a control/status word, two 32-bit address words that together form a 64-bit address, and two 32-bit data words. Writing the control word with its read-start bit set launches a read. Writing data word 0 launches a write. The engine then drives one request on a request/response memory port and waits for the answer.

The parameter `MAX_BITS` sets the widest access the engine may issue: 0, 8, 16, 32 or 64. It decides which sizes are legal, which capability flags read back, and whether the version and address-width fields report a present bus master. A value of 0 turns the master off completely: every access is rejected and the engine never touches the bus. When auto-increment is on, the 64-bit address steps by the access size after every completed access.

Top module: `sba_engine`

## Requirements
- R1: The size field (control bits [2:0]) encodes 0 as 1 byte, 1 as 2 bytes, 2 as 4 bytes and 3 as 8 bytes. A legal start drives `mem_req` high for exactly one cycle, on the clock edge that accepts the start. `mem_size` carries the size code during that cycle.
- R2: A start whose size code is above 3, or whose size in bits exceeds `MAX_BITS`, sets the error field (control bits [6:4]) to 3 and raises no `mem_req`.
- R3: A response with `mem_fault` high sets the error field to 2 and leaves both data words unchanged.
- R4: Capability flags at control bits 9, 10, 11 and 12 stand for 8-, 16-, 32- and 64-bit access. Each flag reads 1 only when `MAX_BITS` is at least that width.
- R5: The version field (control bits [22:20]) reads 1 and the address-width field (bits [19:13]) reads 64 when `MAX_BITS` is nonzero. Otherwise both read 0.
- R6: `mem_addr` is address word 1 (register select 2) placed above address word 0 (register select 1).
- R7: When auto-increment (control bit 3) is set and `MAX_BITS` is nonzero, a completed access adds the access size in bytes to the 64-bit address, with carry from word 0 into word 1. When auto-increment is clear, the address is unchanged.
- R8: A read fills data word 0 (select 3) with the returned data zero-extended from the access size. A 64-bit read also puts bits [63:32] into data word 1 (select 4). A write drives `mem_wdata` as data word 1 above data word 0.
- R9: The busy flag (control bit 7) is set from the accepted start until `mem_rsp`. While busy, these are ignored: starts, writes to the address and data words, and changes to the size and auto-increment fields.
- R10: Writing 1s to the error field clears those bits. If an error is set in the same cycle as a clear, the new error code wins. Register selects: 0 control, 1 address word 0, 2 address word 1, 3 data word 0, 4 data word 1. A control write with bit 8 set starts a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| mem_req | output | 1 | One-cycle access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data |
| mem_rsp | input | 1 | Access response |
| mem_rdata | input | 64 | Read data, right-aligned |
| mem_fault | input | 1 | Response carries a bus fault |

## Verification
Two events can land on the same edge. One is an error being raised: a fault response, or a rejected start. The other is a write-1-to-clear of the error field. The bench provokes the first case by presenting a faulting response together with a control write that clears all error bits. It provokes the second case by combining an illegal-size start with a clear in one write. In both cases it expects the new code to survive. It also checks a partial clear that turns code 3 into code 2. Three copies of the engine with different maximum widths share the same stimulus, so one size sweep compares the accepted, rejected and disabled behaviours against a model computed in the bench.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_ALO  = 3'd1,
    SEL_AHI  = 3'd2,
    SEL_D0   = 3'd3,
    SEL_D1   = 3'd4
  } sba_sel_e;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_FAULT = 3'd2;
  localparam logic [2:0] ERR_SIZE  = 3'd3;

  // bytes moved by one access of the given size code
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // an access size is legal when it exists and fits the configured width
  function automatic logic size_ok(input logic [2:0] code, input int max_bits);
    if (code > 3'd3) return 1'b0;
    return int'(32'd8 << code) <= max_bits;
  endfunction

  // capability flags, bit i set for a width of 8<<i
  function automatic logic [3:0] caps_for(input int max_bits);
    logic [3:0] c;
    for (int i = 0; i < 4; i++) c[i] = (8 << i) <= max_bits;
    return c;
  endfunction

endpackage

// File: rtl/sba_size_check.sv
module sba_size_check
  import sba_pkg::*;
#(
  parameter int MAX_BITS = 64
) (
  input  logic [2:0] code,
  output logic       legal
);
  assign legal = size_ok(code, MAX_BITS);
endmodule

// File: rtl/sba_addr_step.sv
module sba_addr_step
  import sba_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  input  logic [1:0]  code,
  input  logic        step,
  output logic [31:0] next_lo,
  output logic [31:0] next_hi
);
  generate
    if (ENABLE) begin : g_step
      logic [63:0] sum;
      assign sum = {hi, lo} + (step ? 64'(size_bytes(code)) : 64'd0);
      assign next_lo = sum[31:0];
      assign next_hi = sum[63:32];
    end else begin : g_hold
      logic unused_in;
      assign unused_in = step ^ (^code);
      assign next_lo = lo;
      assign next_hi = hi;
    end
  endgenerate
endmodule

// File: rtl/sba_read_fit.sv
module sba_read_fit (
  input  logic [1:0]  code,
  input  logic [63:0] raw,
  input  logic [31:0] d1_old,
  output logic [31:0] d0_new,
  output logic [31:0] d1_new
);
  always_comb begin
    unique case (code)
      2'd0:    d0_new = {24'd0, raw[7:0]};
      2'd1:    d0_new = {16'd0, raw[15:0]};
      default: d0_new = raw[31:0];
    endcase
    d1_new = (code == 2'd3) ? raw[63:32] : d1_old;
  end
endmodule

// File: rtl/sba_engine.sv
module sba_engine
  import sba_pkg::*;
#(
  parameter int MAX_BITS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [1:0]  mem_size,
  output logic [63:0] mem_wdata,
  input  logic        mem_rsp,
  input  logic [63:0] mem_rdata,
  input  logic        mem_fault
);
  localparam bit         HAS_MASTER  = (MAX_BITS > 0);
  localparam logic [2:0] VERSION_RPT = HAS_MASTER ? 3'd1 : 3'd0;
  localparam logic [6:0] AWIDTH_RPT  = HAS_MASTER ? 7'd64 : 7'd0;
  localparam logic [3:0] CAPS        = caps_for(MAX_BITS);

  logic [2:0]  size_q, err_q, err_d;
  logic        auto_q, busy_q, req_q, we_q;
  logic [31:0] alo_q, ahi_q, d0_q, d1_q;

  // named events used by logic and assertions
  logic       wr_ctrl, wr_alo, wr_ahi, wr_d0, wr_d1;
  logic       start_req, start_legal, issue, reject, rsp_fire;
  logic [2:0] start_code;
  logic [31:0] step_lo, step_hi, fit_d0, fit_d1;

  assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
  assign wr_alo  = reg_we && (reg_sel == SEL_ALO);
  assign wr_ahi  = reg_we && (reg_sel == SEL_AHI);
  assign wr_d0   = reg_we && (reg_sel == SEL_D0);
  assign wr_d1   = reg_we && (reg_sel == SEL_D1);

  assign start_code = wr_ctrl ? reg_wdata[2:0] : size_q;
  assign start_req  = !busy_q && ((wr_ctrl && reg_wdata[8]) || wr_d0);
  assign issue      = start_req && start_legal;
  assign reject     = start_req && !start_legal;
  assign rsp_fire   = busy_q && mem_rsp;

  sba_size_check #(.MAX_BITS(MAX_BITS)) u_size (
    .code  (start_code),
    .legal (start_legal)
  );

  sba_addr_step #(.ENABLE(HAS_MASTER)) u_step (
    .lo      (alo_q),
    .hi      (ahi_q),
    .code    (size_q[1:0]),
    .step    (auto_q),
    .next_lo (step_lo),
    .next_hi (step_hi)
  );

  sba_read_fit u_fit (
    .code   (size_q[1:0]),
    .raw    (mem_rdata),
    .d1_old (d1_q),
    .d0_new (fit_d0),
    .d1_new (fit_d1)
  );

  // error field: clear first, then any new code wins
  always_comb begin
    err_d = err_q;
    if (wr_ctrl) err_d = err_d & ~reg_wdata[6:4];
    if (reject) err_d = ERR_SIZE;
    if (rsp_fire && mem_fault) err_d = ERR_FAULT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      auto_q <= 1'b0;
      err_q  <= ERR_NONE;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      alo_q  <= '0;
      ahi_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
    end else begin
      err_q <= err_d;
      req_q <= issue;
      if (issue) begin
        busy_q <= 1'b1;
        we_q   <= wr_d0;
      end
      if (!busy_q) begin
        if (wr_ctrl) begin
          size_q <= reg_wdata[2:0];
          auto_q <= reg_wdata[3];
        end
        if (wr_alo) alo_q <= reg_wdata;
        if (wr_ahi) ahi_q <= reg_wdata;
        if (wr_d0)  d0_q  <= reg_wdata;
        if (wr_d1)  d1_q  <= reg_wdata;
      end
      if (rsp_fire) begin
        busy_q <= 1'b0;
        alo_q  <= step_lo;
        ahi_q  <= step_hi;
        if (!we_q && !mem_fault) begin
          d0_q <= fit_d0;
          d1_q <= fit_d1;
        end
      end
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL: reg_rdata = {9'd0, VERSION_RPT, AWIDTH_RPT, CAPS, 1'b0,
                             busy_q, err_q, auto_q, size_q};
      SEL_ALO:  reg_rdata = alo_q;
      SEL_AHI:  reg_rdata = ahi_q;
      SEL_D0:   reg_rdata = d0_q;
      SEL_D1:   reg_rdata = d1_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = {ahi_q, alo_q};
  assign mem_size  = size_q[1:0];
  assign mem_wdata = {d1_q, d0_q};

  // R1: a request lasts one cycle
  a_r1_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R2: a request only goes out for a size the configuration allows
  a_r2_req_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> size_ok(size_q, MAX_BITS));

  // R2: a rejected start leaves code 3
  a_r2_reject_code: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err_q == ERR_SIZE) && !mem_req);

  // R3: a faulting response leaves code 2 and the data words alone
  a_r3_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && mem_fault |=> (err_q == ERR_FAULT) && $stable(d0_q) && $stable(d1_q));

  // R7: completion steps the address by the access size when enabled
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && auto_q && HAS_MASTER |=>
      {ahi_q, alo_q} == $past({ahi_q, alo_q}) + 64'($past(size_bytes(size_q[1:0]))));

  // R9: busy covers the request and ends at the response
  a_r9_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy_q);

  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> !busy_q);

  // R9: address is frozen while waiting
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !mem_rsp |=> $stable(alo_q) && $stable(ahi_q) && $stable(size_q));

endmodule

// File: tb/test_sba_engine.sv
module test_sba_engine;

  localparam int NI = 3;
  localparam int MAXV [NI] = '{64, 16, 0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_sel;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic        mem_rsp;
  logic [63:0] mem_rdata;
  logic        mem_fault;

  logic [31:0] rd   [NI];
  logic        req  [NI];
  logic        mwe  [NI];
  logic [63:0] madr [NI];
  logic [1:0]  msz  [NI];
  logic [63:0] mwd  [NI];

  always #2 clk = ~clk;

  sba_engine #(.MAX_BITS(64)) i_sba_engine (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd[0]), .mem_req(req[0]),
    .mem_we(mwe[0]), .mem_addr(madr[0]), .mem_size(msz[0]),
    .mem_wdata(mwd[0]), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
    .mem_fault(mem_fault));

  sba_engine #(.MAX_BITS(16)) i_sba_engine_narrow (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd[1]), .mem_req(req[1]),
    .mem_we(mwe[1]), .mem_addr(madr[1]), .mem_size(msz[1]),
    .mem_wdata(mwd[1]), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
    .mem_fault(mem_fault));

  sba_engine #(.MAX_BITS(0)) i_sba_engine_none (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd[2]), .mem_req(req[2]),
    .mem_we(mwe[2]), .mem_addr(madr[2]), .mem_size(msz[2]),
    .mem_wdata(mwd[2]), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
    .mem_fault(mem_fault));

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // bench model state, built from the requirements
  logic [2:0]  esz  [NI];
  logic        eau  [NI];
  logic [2:0]  eerr [NI];
  logic        eb   [NI];
  logic        ewe  [NI];
  logic        ereq [NI];
  logic [31:0] ealo [NI], eahi [NI], ed0 [NI], ed1 [NI];

  function automatic bit legal(input int k, input int code);
    if (code > 3) return 1'b0;
    return (8 * (1 << code)) <= MAXV[k];
  endfunction

  function automatic logic [31:0] ctrl_exp(input int k);
    logic [3:0] caps;
    logic [2:0] ver;
    logic [6:0] aw;
    caps = {MAXV[k] >= 64, MAXV[k] >= 32, MAXV[k] >= 16, MAXV[k] >= 8};
    ver  = (MAXV[k] != 0) ? 3'd1 : 3'd0;
    aw   = (MAXV[k] != 0) ? 7'd64 : 7'd0;
    return {9'd0, ver, aw, caps, 1'b0, eb[k], eerr[k], eau[k], esz[k]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input int k, input bit w, input logic [2:0] s, input logic [31:0] d,
                       input bit r, input logic [63:0] raw, input bit f);
    bit st, rdop, rf;
    logic [63:0] a;
    st = 1'b0; rdop = 1'b0;
    rf = r && eb[k];
    ereq[k] = 1'b0;
    if (w) begin
      case (s)
        3'd0: begin
          eerr[k] = eerr[k] & ~d[6:4];
          if (!eb[k]) begin esz[k] = d[2:0]; eau[k] = d[3]; st = d[8]; rdop = 1'b1; end
        end
        3'd1: if (!eb[k]) ealo[k] = d;
        3'd2: if (!eb[k]) eahi[k] = d;
        3'd3: if (!eb[k]) begin ed0[k] = d; st = 1'b1; end
        3'd4: if (!eb[k]) ed1[k] = d;
        default: ;
      endcase
    end
    if (st) begin
      if (legal(k, int'(esz[k]))) begin eb[k] = 1'b1; ereq[k] = 1'b1; ewe[k] = !rdop; end
      else eerr[k] = 3'd3;
    end
    if (rf) begin
      eb[k] = 1'b0;
      if (f) eerr[k] = 3'd2;
      else if (!ewe[k]) begin
        case (esz[k][1:0])
          2'd0: ed0[k] = raw & 64'hFF;
          2'd1: ed0[k] = raw & 64'hFFFF;
          2'd2: ed0[k] = raw[31:0];
          default: begin ed0[k] = raw[31:0]; ed1[k] = raw[63:32]; end
        endcase
      end
      if (eau[k] && MAXV[k] > 0) begin
        a = {eahi[k], ealo[k]} + 64'(1 << esz[k][1:0]);
        ealo[k] = a[31:0];
        eahi[k] = a[63:32];
      end
    end
  endtask

  task automatic step(input bit w, input logic [2:0] s, input logic [31:0] d,
                      input bit r, input logic [63:0] raw, input bit f);
    @(negedge clk);
    reg_we = w; reg_sel = s; reg_wdata = d;
    mem_rsp = r; mem_rdata = raw; mem_fault = f;
    @(posedge clk);
    for (int k = 0; k < NI; k++) model(k, w, s, d, r, raw, f);
    #1;
    reg_we = 1'b0; mem_rsp = 1'b0; mem_fault = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    step(1'b1, s, d, 1'b0, 64'd0, 1'b0);
  endtask

  task automatic rsp(input logic [63:0] raw, input bit f);
    step(1'b0, 3'd0, 32'd0, 1'b1, raw, f);
  endtask

  // called right after a step: request first, then register readback
  task automatic check_all(input string tag);
    for (int k = 0; k < NI; k++) chk(tag, "mem_req", 64'(req[k]), 64'(ereq[k]));
    for (int k = 0; k < NI; k++) begin
      for (int s = 0; s < 5; s++) begin
        logic [31:0] e;
        reg_sel = 3'(s);
        #1;
        case (s)
          0: e = ctrl_exp(k);
          1: e = ealo[k];
          2: e = eahi[k];
          3: e = ed0[k];
          default: e = ed1[k];
        endcase
        chk(tag, $sformatf("inst%0d sel%0d", k, s), 64'(rd[k]), 64'(e));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 3'd0; reg_wdata = '0;
    mem_rsp = 1'b0; mem_rdata = '0; mem_fault = 1'b0;
    for (int k = 0; k < NI; k++) begin
      esz[k] = 0; eau[k] = 0; eerr[k] = 0; eb[k] = 0; ewe[k] = 0; ereq[k] = 0;
      ealo[k] = 0; eahi[k] = 0; ed0[k] = 0; ed1[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R4");  // reset state plus capability flags
    check_all("R5");  // version and address width fields

    // size sweep: every code, both directions, three widths at once
    for (int c = 0; c < 8; c++) begin
      for (int dir = 0; dir < 2; dir++) begin
        logic [31:0] lo, hi;
        logic [63:0] raw;
        lo  = 32'hFFFF_FFF8 + 32'(c);
        hi  = 32'(c * 16 + 1);
        raw = {32'h9000_0000 + 32'(c * 17), 32'h8765_4300 + 32'(c * 257 + dir)};
        wr(3'd1, lo);
        wr(3'd2, hi);
        if (dir == 1) begin
          wr(3'd4, 32'h5A00_0000 + 32'(c));
          wr(3'd0, 32'h78 | 32'(c));
          wr(3'd3, 32'hC300_0000 + 32'(c * 3));
        end else begin
          wr(3'd0, 32'h178 | 32'(c));
        end
        if (legal(0, c)) begin
          chk("R1", "mem_size", 64'(msz[0]), 64'(c));
          chk("R6", "mem_addr", madr[0], {hi, lo});
          chk("R8", "mem_we", 64'(mwe[0]), 64'(dir));
          if (dir == 1) chk("R8", "mem_wdata", mwd[0], {ed1[0], ed0[0]});
        end
        check_all("R2");
        rsp(raw, 1'b0);
        chk("R1", "req after pulse", 64'(req[0]), 64'd0);
        check_all("R7");
      end
    end

    // bus fault on a 32-bit read
    wr(3'd0, 32'h17A);
    rsp(64'hDEAD_BEEF_0BAD_F00D, 1'b1);
    check_all("R3");

    // fault response and full clear in the same cycle: fault code survives
    wr(3'd0, 32'h178);
    step(1'b1, 3'd0, 32'h0000_0078, 1'b1, 64'h1111_2222_3333_4444, 1'b1);
    check_all("R10");
    wr(3'd0, 32'h70);
    check_all("R10");

    // illegal start and full clear in one write, then a partial clear 3 -> 2
    wr(3'd0, 32'h17F);
    check_all("R10");
    wr(3'd0, 32'h10);
    check_all("R10");
    wr(3'd0, 32'h70);

    // writes while busy are dropped
    wr(3'd1, 32'h0000_1000);
    wr(3'd0, 32'h179);
    check_all("R9");
    wr(3'd1, 32'h0000_1234);
    check_all("R9");
    wr(3'd0, 32'h178);
    check_all("R9");
    wr(3'd3, 32'h0000_CAFE);
    check_all("R9");
    rsp(64'h0123_4567_89AB_CDEF, 1'b0);
    check_all("R9");

    // auto-increment off: address stays put
    wr(3'd0, 32'h172);
    rsp(64'h0F0F_0F0F_F0F0_F0F0, 1'b0);
    check_all("R7");

    // 64-bit write with auto-increment across the low-word carry
    wr(3'd1, 32'hFFFF_FFFC);
    wr(3'd2, 32'h0000_00FF);
    wr(3'd4, 32'hAAAA_5555);
    wr(3'd0, 32'h7B);
    wr(3'd3, 32'h1357_9BDF);
    chk("R8", "mem_wdata", mwd[0], 64'hAAAA_5555_1357_9BDF);
    chk("R6", "mem_addr", madr[0], 64'h0000_00FF_FFFF_FFFC);
    rsp(64'd0, 1'b0);
    check_all("R7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule